// File: doc/BRIEF.md
# Test Vector Pin Stimulus Sequencer

This block applies one already-decoded functional test vector to a row of device pins and judges the response. Each pin receives a 4-bit condition code. A start strobe captures the codes and a default input level. The block then steps through five phases of equal, parameterised length: steady inputs, clock pulse, pulse return, check with a weak pull-up, and check with a weak pull-down.

During the run it drives per-pin output-enable and output-value signals, and a pull-select signal that tells the tester which weak pull to place on undriven pins. It samples the pin values near the end of each check phase. At the end it raises a one-cycle done pulse, with a pass flag and one fail bit per pin. Codes it does not know are treated as not tested.

Top module: `vector_pin_sequencer`

## Requirements
- R1: After reset, busy, done, pass, every output enable and every fail bit are 0, and pull-select is 1.
- R2: Code 0 drives the pin low and code 1 drives it high. Code 2 drives the default level captured at start. All three drive during the whole run.
- R3: Code 3 (float), 6 (expect high), 7 (expect low), 8 (not tested), 9 (expect high impedance) and the unused codes 10 to 15 never enable the pin driver.
- R4: Code 4 drives low in the steady phase, high in the pulse phase, and low in the return and check phases. Code 5 drives the inverse levels at the same times.
- R5: The phases run in the order steady, pulse, return, check-up, check-down, each lasting SETTLE cycles. Done is seen in the cycle after 5*SETTLE cycles of busy.
- R6: Pull-select is 1 (pull-up) in every cycle except during the check-down phase, where it is 0 (pull-down).
- R7: A code 6 pin passes only if it reads 1 at both check samples. A code 7 pin passes only if it reads 0 at both.
- R8: A code 9 pin passes only if it reads 1 under the pull-up and 0 under the pull-down.
- R9: Pins with any other code never fail. Pass is 1 exactly when no fail bit is set. Done lasts one cycle, and pass and the fail bits hold until the next accepted start.
- R10: Start is ignored while busy. Changes on the codes or the default level after an accepted start do not affect the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| cond_i | input | NUM_PINS*4 | Condition code per pin, pin i in bits [4i+3:4i] |
| dflt_lvl_i | input | 1 | Level driven by code 2 |
| pin_in_i | input | NUM_PINS | Sampled pin values |
| pin_oe_o | output | NUM_PINS | Per-pin driver enable |
| pin_val_o | output | NUM_PINS | Per-pin driven value |
| pull_up_o | output | 1 | Weak pull selection, 1 = up, 0 = down |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run had no failing pin |
| fail_mask_o | output | NUM_PINS | Per-pin fail bits of the last run |

## Verification
The bench sweeps every code from 0 to 10 on each of two pins, against a modelled device that drives 0, drives 1 or floats, with both default levels. This covers every pairing of conditions. A driving device separates the expect-high and expect-low checks from the high-impedance check. A floating device separates a real high-impedance pin from a stuck level, because only that case follows both pulls. In every cycle of every run the bench checks the enables, the driven levels and the pull-select against the phase computed from the cycle count. This exposes any error in the pulse timing of codes 4 and 5 or in the phase length. The codes, default level and start are changed during each run to show that they are captured at start.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CD_ZERO    = 4'd0,
        CD_ONE     = 4'd1,
        CD_DFLT    = 4'd2,
        CD_FLOAT   = 4'd3,
        CD_CLK_LHL = 4'd4,
        CD_CLK_HLH = 4'd5,
        CD_EXP_HI  = 4'd6,
        CD_EXP_LO  = 4'd7,
        CD_SKIP    = 4'd8,
        CD_EXP_Z   = 4'd9
    } cond_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_STEADY = 3'd1,
        PH_PULSE  = 3'd2,
        PH_RETURN = 3'd3,
        PH_CHK_UP = 3'd4,
        PH_CHK_DN = 3'd5
    } phase_e;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    function automatic drive_t drive_of(logic [CODE_W-1:0] code, phase_e ph, logic dflt);
        drive_t d;
        d.oe  = 1'b0;
        d.val = 1'b0;
        if (ph != PH_IDLE) begin
            case (code)
                CD_ZERO:    begin d.oe = 1'b1; d.val = 1'b0; end
                CD_ONE:     begin d.oe = 1'b1; d.val = 1'b1; end
                CD_DFLT:    begin d.oe = 1'b1; d.val = dflt; end
                CD_CLK_LHL: begin d.oe = 1'b1; d.val = (ph == PH_PULSE); end
                CD_CLK_HLH: begin d.oe = 1'b1; d.val = (ph != PH_PULSE); end
                default:    begin d.oe = 1'b0; d.val = 1'b0; end
            endcase
        end
        return d;
    endfunction

    function automatic logic judge(logic [CODE_W-1:0] code, logic up_s, logic dn_s);
        case (code)
            CD_EXP_HI: return !(up_s && dn_s);
            CD_EXP_LO: return up_s || dn_s;
            CD_EXP_Z:  return !(up_s && !dn_s);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pinseq_timer.sv
module pinseq_timer
    import pinseq_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   load,
    output logic   smp_up,
    output logic   smp_dn,
    output logic   done,
    output logic   res_valid
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == LAST);
    assign load   = start && (phase == PH_IDLE);
    assign smp_up = (phase == PH_CHK_UP) && at_end;
    assign smp_dn = (phase == PH_CHK_DN) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            done      <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            done <= smp_dn;
            if (load) begin
                phase     <= PH_STEADY;
                cnt       <= '0;
                res_valid <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (at_end) begin
                    cnt <= '0;
                    case (phase)
                        PH_STEADY: phase <= PH_PULSE;
                        PH_PULSE:  phase <= PH_RETURN;
                        PH_RETURN: phase <= PH_CHK_UP;
                        PH_CHK_UP: phase <= PH_CHK_DN;
                        default:   phase <= PH_IDLE;
                    endcase
                    if (phase == PH_CHK_DN) res_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: a phase is only left after its full count
    a_r5_phase_len: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase) && $past(phase) != PH_IDLE) |-> ($past(cnt) == LAST));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a start during a run does not send the sequence back to the steady phase
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (start && phase == PH_PULSE) |=> (phase != PH_STEADY));

endmodule

// File: rtl/pinseq_pin.sv
module pinseq_pin
    import pinseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] cond_in,
    input  logic              dflt_in,
    input  phase_e            phase,
    input  logic              smp_up,
    input  logic              smp_dn,
    input  logic              pin_in,
    output logic              oe,
    output logic              val,
    output logic              fail
);
    logic [CODE_W-1:0] cond_q;
    logic              dflt_q;
    logic              up_q;
    drive_t            drv;

    assign drv = drive_of(cond_q, phase, dflt_q);
    assign oe  = drv.oe;
    assign val = drv.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= CD_SKIP;
            dflt_q <= 1'b0;
            up_q   <= 1'b0;
            fail   <= 1'b0;
        end else begin
            if (load) begin
                cond_q <= cond_in;
                dflt_q <= dflt_in;
                fail   <= 1'b0;
            end
            if (smp_up) up_q <= pin_in;
            if (smp_dn) fail <= judge(cond_q, up_q, pin_in);
        end
    end

    // R3: non-driving codes keep the driver off
    a_r3_no_drive: assert property (@(posedge clk) disable iff (rst)
        (cond_q == CD_FLOAT || cond_q == CD_EXP_HI || cond_q == CD_EXP_LO ||
         cond_q == CD_SKIP || cond_q == CD_EXP_Z || cond_q > CD_EXP_Z) |-> !oe);

    // R4: a low-high-low clock pin only rises on entry to the pulse phase
    a_r4_pulse_rise: assert property (@(posedge clk) disable iff (rst)
        (cond_q == CD_CLK_LHL && $rose(val)) |-> (phase == PH_PULSE));

endmodule

// File: rtl/vector_pin_sequencer.sv
module vector_pin_sequencer
    import pinseq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int SETTLE   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [NUM_PINS*CODE_W-1:0] cond_i,
    input  logic                       dflt_lvl_i,
    input  logic [NUM_PINS-1:0]        pin_in_i,
    output logic [NUM_PINS-1:0]        pin_oe_o,
    output logic [NUM_PINS-1:0]        pin_val_o,
    output logic                       pull_up_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       pass_o,
    output logic [NUM_PINS-1:0]        fail_mask_o
);
    phase_e phase;
    logic   load, smp_up, smp_dn, res_valid;

    pinseq_timer #(.SETTLE(SETTLE)) u_timer (
        .clk(clk), .rst(rst), .start(start_i), .phase(phase), .load(load),
        .smp_up(smp_up), .smp_dn(smp_dn), .done(done_o), .res_valid(res_valid)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pinseq_pin u_pin (
            .clk(clk), .rst(rst), .load(load),
            .cond_in(cond_i[i*CODE_W +: CODE_W]), .dflt_in(dflt_lvl_i),
            .phase(phase), .smp_up(smp_up), .smp_dn(smp_dn),
            .pin_in(pin_in_i[i]), .oe(pin_oe_o[i]), .val(pin_val_o[i]),
            .fail(fail_mask_o[i])
        );
    end

    assign busy_o    = (phase != PH_IDLE);
    assign pull_up_o = (phase != PH_CHK_DN);
    assign pass_o    = res_valid && !(|fail_mask_o);

    // R6: the pull-down is only selected inside a run
    a_r6_pull_in_run: assert property (@(posedge clk) disable iff (rst)
        !pull_up_o |-> busy_o);

    // R9: results hold between done and the next start
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && !done_o) |=> $stable(fail_mask_o));

endmodule

// File: tb/vector_pin_sequencer_test.sv
module vector_pin_sequencer_test;
    localparam int NP = 2;
    localparam int ST = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NP*4-1:0] cond = '0;
    logic            dflt = 1'b0;
    logic [NP-1:0]   pin_in;
    logic [NP-1:0]   oe, val, fmask;
    logic            pull_up, busy, done, pass;
    int              dev [NP];   // 0 drives low, 1 drives high, 2 floats
    int              checks = 0, failures = 0;
    bit              finished = 0;

    always #2.5 clk = ~clk;

    vector_pin_sequencer #(.NUM_PINS(NP), .SETTLE(ST)) uut (
        .clk(clk), .rst(rst), .start_i(start), .cond_i(cond), .dflt_lvl_i(dflt),
        .pin_in_i(pin_in), .pin_oe_o(oe), .pin_val_o(val), .pull_up_o(pull_up),
        .busy_o(busy), .done_o(done), .pass_o(pass), .fail_mask_o(fmask)
    );

    always_comb
        for (int i = 0; i < NP; i++)
            pin_in[i] = oe[i] ? val[i] : (dev[i] == 2 ? pull_up : dev[i][0]);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_fail(int code, int d);
        bit up_s = (d == 2) ? 1'b1 : d[0];
        bit dn_s = (d == 2) ? 1'b0 : d[0];
        case (code)
            6: return !(up_s && dn_s);
            7: return up_s || dn_s;
            9: return !(up_s && !dn_s);
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input int c0, input int c1, input bit dl);
        int  codes [NP];
        bit  ef [NP];
        bit  any_fail = 0;
        codes[0] = c0; codes[1] = c1;
        cond = {4'(c1), 4'(c0)};
        dflt = dl;
        start = 1'b1;
        for (int j = 0; j < 5*ST; j++) begin
            int p;
            @(negedge clk);
            p = j / ST;
            // R10: disturb the inputs after the accepted start
            cond = ~cond;
            dflt = ~dl;
            if (j == 5*ST-1) start = 1'b0;
            chk(busy == 1'b1, "R5 busy", busy, 1);
            chk(pull_up == (p != 4), "R6 pull", pull_up, p != 4);
            for (int i = 0; i < NP; i++) begin
                bit eo = (codes[i] <= 2 || codes[i] == 4 || codes[i] == 5);
                bit ev = (codes[i] == 1) || (codes[i] == 2 && dl) ||
                         (codes[i] == 4 && p == 1) || (codes[i] == 5 && p != 1);
                chk(oe[i] == eo, eo ? "R2/R4 enable" : "R3 enable", oe[i], eo);
                if (eo) chk(val[i] == ev, (codes[i] >= 4) ? "R4 level" : "R2 level", val[i], ev);
            end
        end
        @(negedge clk);
        cond = {4'(c1), 4'(c0)};
        dflt = dl;
        chk(done == 1'b1, "R5 done time", done, 1);
        chk(busy == 1'b0, "R5 end busy", busy, 0);
        for (int i = 0; i < NP; i++) begin
            ef[i] = exp_fail(codes[i], dev[i]);
            any_fail |= ef[i];
            chk(fmask[i] == ef[i],
                (codes[i] == 9) ? "R8 z check" : (codes[i] == 6 || codes[i] == 7) ? "R7 level check" : "R9 untested",
                fmask[i], ef[i]);
        end
        chk(pass == !any_fail, "R9 pass", pass, !any_fail);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(pass == !any_fail, "R9 pass held", pass, !any_fail);
    endtask

    initial begin
        dev[0] = 2; dev[1] = 2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && pass == 0, "R1 flags", {busy, done, pass}, 0);
        chk(oe == '0 && fmask == '0, "R1 pins", {oe, fmask}, 0);
        chk(pull_up == 1'b1, "R1 pull", pull_up, 1);
        for (int d0 = 0; d0 < 3; d0++)
            for (int d1 = 0; d1 < 3; d1++)
                for (int c0 = 0; c0 <= 10; c0++)
                    for (int c1 = 0; c1 <= 10; c1++)
                        for (int dl = 0; dl < 2; dl++) begin
                            dev[0] = d0; dev[1] = d1;
                            run(c0, c1, dl[0]);
                        end
        // R3: top unused code 15 behaves as not tested
        dev[0] = 0; dev[1] = 1;
        run(15, 15, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule